// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a system between four operating modes: a gated sleep mode, a low-speed doze mode, a crystal-driven slow mode and a PLL-driven normal mode. Software writes a 3-bit mode request register. The controller turns that request into a safe sequence of oscillator enables, clock-source selects and clock gates. It never changes the clock source directly from one steady mode to another. Every change goes through its own transition state: crystal start-up, PLL lock, switching away from the PLL, or switching away from the crystal.

An interrupt that arrives while the system sleeps brings it back to doze. The hardware then rewrites the request register to the doze code, so that software finds a value that matches the mode it is in. Doze falls back to sleep only when the register holds all zeros and the processor reports wait-for-interrupt. The glitch-free clock multiplexers that act on the selects are outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is in doze. The request register reads 3'b001, `clk_sel` is 2'b00 (low-speed oscillator), both clock gates are 1, and `xtal_en`, `pll_en` and `in_transit` are 0.
- R2: A cycle with `mode_wr_en` high loads `mode_wr_data` into the request register, which reads back on `mode_reg_q` after that edge. The codes are sleep 3'b000, doze 3'b001, slow 3'b010 and normal 3'b100. `mode_now` reports the mode whose clock source is in effect, using the same codes.
- R3: Doze goes to sleep only on an edge where the register is 3'b000 and `cpu_wfi` is high. In sleep, `sys_clk_en` and `cpu_clk_en` are 0, `clk_sel` is 2'b00 and `mode_now` is 3'b000.
- R4: In sleep, a high `irq_pend` moves the controller to doze on the next edge and sets the request register to 3'b001 on that same edge.
- R5: In doze, a register with bit 1 or bit 2 set enters crystal start-up on the next edge. Start-up raises `xtal_en` and `in_transit`, keeps `clk_sel` at 2'b00 and reports doze.
- R6: Crystal start-up moves to slow on the edge after `xtal_stable` is seen. Without `xtal_stable`, it moves to slow after exactly `XTAL_TMO_CYC` cycles in the state. Slow drives `clk_sel` to 2'b01.
- R7: In slow, register bit 2 enters PLL start-up, which raises `pll_en` and keeps `clk_sel` at 2'b01. A high `pll_locked` then moves the controller to normal, with `clk_sel` 2'b10 and `mode_now` 3'b100.
- R8: PLL start-up whose register bit 2 has been cleared returns to slow and drops `pll_en`.
- R9: Normal with register bit 2 clear spends one cycle switching away from the PLL (`clk_sel` 2'b01, `in_transit` 1, `pll_en` still 1) and then enters slow with `pll_en` 0.
- R10: Slow with register bits 1 and 2 both clear spends one cycle switching away from the crystal (`clk_sel` 2'b00, `in_transit` 1, `xtal_en` still 1) and then enters doze with `xtal_en` 0.
- R11: Register bit 2 has priority over bit 1. A register value of 3'b100 or 3'b110 in slow leads to PLL start-up, never to the switch away from the crystal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr_en | input | 1 | Write strobe for the request register |
| mode_wr_data | input | 3 | Value written to the request register |
| irq_pend | input | 1 | Interrupt pending (fast or normal) |
| cpu_wfi | input | 1 | Processor is waiting for an interrupt |
| xtal_stable | input | 1 | Crystal oscillator reports a stable output |
| pll_locked | input | 1 | PLL reports lock |
| mode_reg_q | output | 3 | Request register readback |
| mode_now | output | 3 | Mode whose clock source is currently in effect |
| in_transit | output | 1 | Controller is in a transition state |
| sys_clk_en | output | 1 | System clock gate enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| clk_sel | output | 2 | Clock source for system, CPU and controller: 00 low-speed, 01 crystal, 10 PLL |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
A register write is visible on `mode_reg_q` one edge after the strobe. The state machine acts on the new value at the following edge, so the outputs change two edges after the strobe. Handshake inputs, interrupts and `cpu_wfi` take effect on the first edge after they are driven. A crystal start-up without `xtal_stable` lasts exactly `XTAL_TMO_CYC` edges. The bench drives every input on a falling edge and samples on a later falling edge, counting the edges described here. It also checks at the last cycle before each due transition that the old state still holds, which pins down both the latency and the timeout length.

// File: rtl/pmc_pkg.sv
// Package: shared state, clock-source and mode-code definitions for the
// power mode sequencing controller.
package pmc_pkg;
    // Controller states: four steady modes and four transition states.
    typedef enum logic [2:0] {
        PS_DOZE,
        PS_SLEEP,
        PS_XTAL_UP,
        PS_SLOW,
        PS_PLL_UP,
        PS_NORMAL,
        PS_PLL_OFF,
        PS_XTAL_OFF
    } pstate_e;

    // Clock source select codes.
    typedef enum logic [1:0] {
        SRC_LOW  = 2'b00,
        SRC_XTAL = 2'b01,
        SRC_PLL  = 2'b10
    } clksrc_e;

    // Mode codes, used for the request register and for the readback.
    localparam logic [2:0] MODE_SLEEP  = 3'b000;
    localparam logic [2:0] MODE_DOZE   = 3'b001;
    localparam logic [2:0] MODE_SLOW   = 3'b010;
    localparam logic [2:0] MODE_NORMAL = 3'b100;

    // Bit positions the state machine decodes in the request register.
    localparam int BIT_SLOW   = 1;
    localparam int BIT_NORMAL = 2;
endpackage

// File: rtl/pmc_mode_reg.sv
// Module: holds the software mode request register.
// Assumes: a wake request from the state machine only arrives while the
// system sleeps, and it takes priority over a software write on the same edge.
module pmc_mode_reg
    import pmc_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              wake,
    output logic [MODE_W-1:0] mode_q
);
    // Load a software write; a hardware wake forces the doze code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_W'(MODE_DOZE);
        else if (wake)
            mode_q <= MODE_W'(MODE_DOZE);
        else if (wr_en)
            mode_q <= wr_data;
    end

    // R4
    wake_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (mode_q == MODE_W'(MODE_DOZE)));
endmodule

// File: rtl/pmc_xtal_timer.sv
// Module: counts the cycles spent in crystal start-up and flags the timeout.
// Assumes: run stays high for the whole start-up state and drops as soon as
// the state is left; XTAL_TMO_CYC is at least 2.
module pmc_xtal_timer #(
    parameter int XTAL_TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tmo
);
    localparam int CW = $clog2(XTAL_TMO_CYC);
    localparam logic [CW-1:0] LAST = CW'(XTAL_TMO_CYC - 1);

    logic [CW-1:0] cnt;

    // Count up while start-up is running; hold at the limit; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign tmo = run && (cnt == LAST);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == LAST) || (cnt == '0));
endmodule

// File: rtl/pmc_fsm.sv
// Module: mode sequencing state machine.
// Assumes: mode_q is the registered request word; the handshakes
// (xtal_stable, pll_locked) are already synchronous to clk.
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              irq_pend,
    input  logic              cpu_wfi,
    input  logic              xtal_stable,
    input  logic              xtal_tmo,
    input  logic              pll_locked,
    output pstate_e           state,
    output logic              wake
);
    pstate_e nxt;
    logic    want_normal;
    logic    want_slow;

    assign want_normal = mode_q[BIT_NORMAL];
    assign want_slow   = mode_q[BIT_SLOW];
    assign wake        = (state == PS_SLEEP) && irq_pend;

    // Choose the next state from the request bits and the handshakes.
    always_comb begin
        nxt = state;
        case (state)
            PS_SLEEP:    if (irq_pend) nxt = PS_DOZE;
            PS_DOZE: begin
                if (want_normal || want_slow)
                    nxt = PS_XTAL_UP;
                else if ((mode_q == '0) && cpu_wfi)
                    nxt = PS_SLEEP;
            end
            PS_XTAL_UP:  if (xtal_stable || xtal_tmo) nxt = PS_SLOW;
            PS_SLOW: begin
                if (want_normal)
                    nxt = PS_PLL_UP;
                else if (!want_slow)
                    nxt = PS_XTAL_OFF;
            end
            PS_PLL_UP: begin
                if (!want_normal)
                    nxt = PS_SLOW;
                else if (pll_locked)
                    nxt = PS_NORMAL;
            end
            PS_NORMAL:   if (!want_normal) nxt = PS_PLL_OFF;
            PS_PLL_OFF:  nxt = PS_SLOW;
            PS_XTAL_OFF: nxt = PS_DOZE;
            default:     nxt = PS_DOZE;
        endcase
    end

    // State register; reset lands in doze.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PS_DOZE;
        else
            state <= nxt;
    end

    // R4
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SLEEP && irq_pend) |=> (state == PS_DOZE));

    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_DOZE && state == PS_SLEEP)
            |-> ($past(cpu_wfi) && $past(mode_q) == '0));

    // R7
    pll_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != PS_NORMAL && state == PS_NORMAL) |-> $past(pll_locked));

    // R9
    pll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_NORMAL && state != PS_NORMAL) |-> (state == PS_PLL_OFF));

    // R10
    slow_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_SLOW && state != PS_SLOW)
            |-> (state == PS_XTAL_OFF || state == PS_PLL_UP));
endmodule

// File: rtl/pmc_clk_out.sv
// Module: decodes the controller state into clock selects, gates,
// oscillator enables and the mode readback.
// Assumes: pure decode; one shared source select drives the system, CPU
// and controller clock multiplexers.
module pmc_clk_out
    import pmc_pkg::*;
(
    input  pstate_e    state,
    output clksrc_e    sel,
    output logic       clk_en,
    output logic       xtal_on,
    output logic       pll_on,
    output logic       transit,
    output logic [2:0] mode_code
);
    // Map each state to the outputs it drives.
    always_comb begin
        sel       = SRC_LOW;
        clk_en    = 1'b1;
        xtal_on   = 1'b0;
        pll_on    = 1'b0;
        transit   = 1'b0;
        mode_code = MODE_DOZE;
        case (state)
            PS_SLEEP: begin
                clk_en    = 1'b0;
                mode_code = MODE_SLEEP;
            end
            PS_DOZE: ;
            PS_XTAL_UP: begin
                xtal_on = 1'b1;
                transit = 1'b1;
            end
            PS_SLOW: begin
                sel       = SRC_XTAL;
                xtal_on   = 1'b1;
                mode_code = MODE_SLOW;
            end
            PS_PLL_UP: begin
                sel       = SRC_XTAL;
                xtal_on   = 1'b1;
                pll_on    = 1'b1;
                transit   = 1'b1;
                mode_code = MODE_SLOW;
            end
            PS_NORMAL: begin
                sel       = SRC_PLL;
                xtal_on   = 1'b1;
                pll_on    = 1'b1;
                mode_code = MODE_NORMAL;
            end
            PS_PLL_OFF: begin
                sel       = SRC_XTAL;
                xtal_on   = 1'b1;
                pll_on    = 1'b1;
                transit   = 1'b1;
                mode_code = MODE_SLOW;
            end
            PS_XTAL_OFF: begin
                xtal_on = 1'b1;
                transit = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: top of the power mode sequencing controller. Ties together the
// request register, the crystal start-up timer, the state machine and the
// output decode.
// Assumes: all inputs are synchronous to clk; the clock multiplexers and
// gates driven by the outputs are glitch-free and sit outside this block.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int XTAL_TMO_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr_en,
    input  logic [2:0] mode_wr_data,
    input  logic       irq_pend,
    input  logic       cpu_wfi,
    input  logic       xtal_stable,
    input  logic       pll_locked,
    output logic [2:0] mode_reg_q,
    output logic [2:0] mode_now,
    output logic       in_transit,
    output logic       sys_clk_en,
    output logic       cpu_clk_en,
    output logic [1:0] clk_sel,
    output logic       xtal_en,
    output logic       pll_en
);
    localparam int MODE_W = 3;

    pstate_e st;
    clksrc_e sel;
    logic    wake;
    logic    tmo;
    logic    gate_en;

    pmc_mode_reg #(.MODE_W(MODE_W)) u_mode_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .wake    (wake),
        .mode_q  (mode_reg_q)
    );

    pmc_xtal_timer #(.XTAL_TMO_CYC(XTAL_TMO_CYC)) u_xtal_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st == PS_XTAL_UP),
        .tmo   (tmo)
    );

    pmc_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_reg_q),
        .irq_pend    (irq_pend),
        .cpu_wfi     (cpu_wfi),
        .xtal_stable (xtal_stable),
        .xtal_tmo    (tmo),
        .pll_locked  (pll_locked),
        .state       (st),
        .wake        (wake)
    );

    pmc_clk_out u_clk_out (
        .state     (st),
        .sel       (sel),
        .clk_en    (gate_en),
        .xtal_on   (xtal_en),
        .pll_on    (pll_en),
        .transit   (in_transit),
        .mode_code (mode_now)
    );

    assign clk_sel    = sel;
    assign sys_clk_en = gate_en;
    assign cpu_clk_en = gate_en;

    // R7
    pll_sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b10) |-> (pll_en && xtal_en));

    // R3
    gate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en) |-> (clk_sel == 2'b00 && !xtal_en && !pll_en));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
// Bench: directed scenarios for the power mode sequencing controller.
// Inputs change on falling edges; outputs are sampled on falling edges.
module test_pwr_mode_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TMO        = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr_en = 1'b0;
    logic [2:0] mode_wr_data = 3'b000;
    logic       irq_pend = 1'b0;
    logic       cpu_wfi = 1'b0;
    logic       xtal_stable = 1'b0;
    logic       pll_locked = 1'b0;
    logic [2:0] mode_reg_q;
    logic [2:0] mode_now;
    logic       in_transit;
    logic       sys_clk_en;
    logic       cpu_clk_en;
    logic [1:0] clk_sel;
    logic       xtal_en;
    logic       pll_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    pwr_mode_ctrl #(.XTAL_TMO_CYC(TMO)) i_pwr_mode_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .irq_pend     (irq_pend),
        .cpu_wfi      (cpu_wfi),
        .xtal_stable  (xtal_stable),
        .pll_locked   (pll_locked),
        .mode_reg_q   (mode_reg_q),
        .mode_now     (mode_now),
        .in_transit   (in_transit),
        .sys_clk_en   (sys_clk_en),
        .cpu_clk_en   (cpu_clk_en),
        .clk_sel      (clk_sel),
        .xtal_en      (xtal_en),
        .pll_en       (pll_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired: actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Packed view of the steady-state outputs: {clk_sel, sys, cpu, xtal, pll, transit}.
    function automatic logic [7:0] outs();
        return {1'b0, clk_sel, sys_clk_en, cpu_clk_en, xtal_en, pll_en, in_transit};
    endfunction

    function automatic logic [7:0] exp_outs(input logic [1:0] s, input logic g,
                                            input logic x, input logic p, input logic t);
        return {1'b0, s, g, g, x, p, t};
    endfunction

    // Write the request register and confirm the readback (R2).
    task automatic wr_mode(input logic [2:0] v);
        @(negedge clk);
        mode_wr_en   = 1'b1;
        mode_wr_data = v;
        @(negedge clk);
        mode_wr_en = 1'b0;
        chk("R2 register readback", {5'b0, mode_reg_q}, {5'b0, v});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset register", {5'b0, mode_reg_q}, 8'h01);
        chk("R1 reset outputs", outs(), exp_outs(2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R1 reset mode_now", {5'b0, mode_now}, 8'h01);
    endtask

    task automatic t_doze_hold();
        cpu_wfi = 1'b1;
        wr_mode(3'b001);
        repeat (2) @(negedge clk);
        chk("R3 doze kept with code 001 and wfi", {5'b0, mode_now}, 8'h01);
        cpu_wfi = 1'b0;
    endtask

    task automatic t_doze_to_sleep();
        wr_mode(3'b000);
        @(negedge clk);
        chk("R3 no sleep without wfi", {5'b0, mode_now}, 8'h01);
        cpu_wfi = 1'b1;
        @(negedge clk);
        chk("R3 sleep mode_now", {5'b0, mode_now}, 8'h00);
        chk("R3 sleep outputs", outs(), exp_outs(2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
        cpu_wfi = 1'b0;
        @(negedge clk);
        chk("R3 sleep holds without irq", {5'b0, mode_now}, 8'h00);
    endtask

    task automatic t_sleep_wake();
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        chk("R4 wake to doze", {5'b0, mode_now}, 8'h01);
        chk("R4 register rewritten", {5'b0, mode_reg_q}, 8'h01);
        chk("R4 clocks on", outs(), exp_outs(2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_xtal_timeout();
        wr_mode(3'b010);
        @(negedge clk);
        chk("R5 crystal start-up outputs", outs(), exp_outs(2'b00, 1'b1, 1'b1, 1'b0, 1'b1));
        chk("R5 start-up reports doze", {5'b0, mode_now}, 8'h01);
        repeat (TMO - 1) @(negedge clk);
        chk("R6 still starting at last cycle", {7'b0, in_transit}, 8'h01);
        @(negedge clk);
        chk("R6 slow after timeout", outs(), exp_outs(2'b01, 1'b1, 1'b1, 1'b0, 1'b0));
        chk("R6 slow mode_now", {5'b0, mode_now}, 8'h02);
    endtask

    task automatic t_slow_to_doze();
        wr_mode(3'b000);
        @(negedge clk);
        chk("R10 switch from crystal", outs(), exp_outs(2'b00, 1'b1, 1'b1, 1'b0, 1'b1));
        @(negedge clk);
        chk("R10 doze reached", outs(), exp_outs(2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_to_normal();
        wr_mode(3'b100);
        @(negedge clk);
        chk("R5 start-up on normal request", {7'b0, in_transit}, 8'h01);
        xtal_stable = 1'b1;
        @(negedge clk);
        chk("R6 slow on xtal_stable", {5'b0, mode_now}, 8'h02);
        @(negedge clk);
        chk("R11 pll start-up from slow", outs(), exp_outs(2'b01, 1'b1, 1'b1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        chk("R7 waits for lock", {5'b0, mode_now}, 8'h02);
        pll_locked = 1'b1;
        @(negedge clk);
        chk("R7 normal outputs", outs(), exp_outs(2'b10, 1'b1, 1'b1, 1'b1, 1'b0));
        chk("R7 normal mode_now", {5'b0, mode_now}, 8'h04);
    endtask

    task automatic t_normal_exit();
        wr_mode(3'b010);
        @(negedge clk);
        chk("R9 switch from pll", outs(), exp_outs(2'b01, 1'b1, 1'b1, 1'b1, 1'b1));
        @(negedge clk);
        chk("R9 slow after pll", outs(), exp_outs(2'b01, 1'b1, 1'b1, 1'b0, 1'b0));
    endtask

    task automatic t_pll_abort();
        pll_locked = 1'b0;
        wr_mode(3'b110);
        @(negedge clk);
        chk("R11 bit2 wins over bit1", {6'b0, pll_en, in_transit}, 8'h03);
        repeat (2) @(negedge clk);
        wr_mode(3'b010);
        @(negedge clk);
        chk("R8 abort back to slow", outs(), exp_outs(2'b01, 1'b1, 1'b1, 1'b0, 1'b0));
    endtask

    initial begin
        t_reset();
        t_doze_hold();
        t_doze_to_sleep();
        t_sleep_wake();
        t_xtal_timeout();
        t_slow_to_doze();
        t_to_normal();
        t_normal_exit();
        t_pll_abort();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule